// File: doc/BRIEF.md
# PHY Management Status Latch

This block keeps the sticky status bits that a station manager reads from an Ethernet PHY. It watches three event sources: a strobe that marks a newly received link code word along with that word's remote-fault flag, and a level from the link monitor saying whether the link is currently good. From these it keeps three pieces of state:

- a remote-fault bit that latches high;
- a link bit that latches low;
- a plain copy of the most recent remote-fault flag.

Three 16-bit status words present this state at fixed management addresses. The read data is combinational from the address. A read strobe on an address that owns a sticky bit rearms that bit on the following clock edge.

The latched remote-fault bit and the latched link bit each appear in two words: the basic status word and the quick-poll word. A read of either word rearms both bits. The serial management framing is outside this block, and so are negotiation arbitration and the rules the link monitor uses.

Top module: `phy_latch_status`

## Requirements
- R1: The latched remote-fault bit sets on the edge where `lcw_stb`=1 with `lcw_rfault`=1. It then stays 1 through later code words that carry `lcw_rfault`=0, until a clearing read. It reads at address 1 bit 4.
- R2: The latched remote-fault bit also reads at address 17 bit 1. A read strobe at address 1 or 17 returns the value held before the clear, and the bit reads 0 from the next cycle on.
- R3: Address 5 bit 13 holds a non-latching copy of `lcw_rfault`, overwritten by every `lcw_stb` pulse. A read of address 5 clears neither latched bit.
- R4: Address 1 bit 3 reads as the parameter `ANEG_ABLE`, which defaults to 1 (negotiation supported).
- R5: The link bit reads at address 1 bit 2 and at address 17 bit 0 (1 = valid). Any cycle with `link_ok`=0 drives it to 0, and it stays 0 after the link recovers until a clearing read.
- R6: After a read strobe at address 1 or 17, the link bit reloads from `link_ok` as sampled on that edge.
- R7: A set event in the same cycle as a clearing read wins. For remote fault this is a code word with the flag at 1. For the link bit it is `link_ok`=0. The bit ends in its event state.
- R8: A synchronous reset (`rst`=1) puts the latched remote-fault bit, the link bit and the address 5 copy at 0.
- R9: Unimplemented bits of addresses 1, 5 and 17 read 0. Every other address reads 0x0000, and a strobe at any other address clears nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr | input | ADDR_W (5) | Management register address |
| rd_stb | input | 1 | Read strobe; clears sticky bits owned by `rd_addr` |
| lcw_stb | input | 1 | One-cycle pulse: new link code word received |
| lcw_rfault | input | 1 | Remote-fault flag of that code word |
| link_ok | input | 1 | Current link-valid level from the link monitor |
| rd_data | output | 16 | Status word for `rd_addr` |

## Verification
`rd_data` is combinational, so a read returns its word in the same cycle the address and strobe are applied. The bench drives inputs on the falling edge and samples `rd_data` a few nanoseconds later, before the rising edge that acts on the strobe. Each clear, reload, latch or copy update lands on that one rising edge. The effect is therefore checked by a read issued on a later falling edge, never in the strobe's own cycle. For the same-cycle races, the event and the strobe are applied on one falling edge. The pre-clear word is checked at once, and the outcome is checked by the next read.

// File: rtl/phy_stat_pkg.sv
package phy_stat_pkg;
  localparam int REG_W        = 16;
  // bit positions a management reader decodes
  localparam int BSR_RF_POS   = 4;
  localparam int BSR_ANEG_POS = 3;
  localparam int BSR_LINK_POS = 2;
  localparam int LPA_RF_POS   = 13;
  localparam int QP_RF_POS    = 1;
  localparam int QP_LINK_POS  = 0;

  typedef struct packed {
    logic rf_latched;
    logic link_latched;
    logic rf_copy;
  } stat_bits_t;

  function automatic logic [REG_W-1:0] bsr_word(input logic rf, input logic aneg,
                                                input logic lnk);
    logic [REG_W-1:0] w;
    w = '0;
    w[BSR_RF_POS]   = rf;
    w[BSR_ANEG_POS] = aneg;
    w[BSR_LINK_POS] = lnk;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] lpa_word(input logic rf);
    logic [REG_W-1:0] w;
    w = '0;
    w[LPA_RF_POS] = rf;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] qp_word(input logic rf, input logic lnk);
    logic [REG_W-1:0] w;
    w = '0;
    w[QP_RF_POS]   = rf;
    w[QP_LINK_POS] = lnk;
    return w;
  endfunction
endpackage

// File: rtl/lh_bit.sv
module lh_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  AST_LH_SET:   assert property (@(posedge clk) disable iff (rst) set_i |=> q_o);          // R1
  AST_LH_HOLD:  assert property (@(posedge clk) disable iff (rst) (q_o && !clr_i) |=> q_o); // R1
  AST_LH_CLEAR: assert property (@(posedge clk) disable iff (rst) (clr_i && !set_i) |=> !q_o); // R2
endmodule

// File: rtl/ll_bit.sv
module ll_bit (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)         q_o <= 1'b0;
    else if (!lvl_i) q_o <= 1'b0;
    else if (clr_i)  q_o <= 1'b1;
  end

  AST_LL_DROP:   assert property (@(posedge clk) disable iff (rst) !lvl_i |=> !q_o);             // R5
  AST_LL_STICK:  assert property (@(posedge clk) disable iff (rst) (!q_o && !clr_i) |=> !q_o);    // R5
  AST_LL_RELOAD: assert property (@(posedge clk) disable iff (rst) clr_i |=> (q_o == $past(lvl_i))); // R6
endmodule

// File: rtl/reg_decode.sv
module reg_decode #(
  parameter int ADDR_W   = 5,
  parameter int BSR_ADDR = 1,
  parameter int LPA_ADDR = 5,
  parameter int QP_ADDR  = 17
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              stb_i,
  output logic              hit_bsr_o,
  output logic              hit_lpa_o,
  output logic              hit_qp_o,
  output logic              clr_o
);
  localparam logic [ADDR_W-1:0] A_BSR = ADDR_W'(BSR_ADDR);
  localparam logic [ADDR_W-1:0] A_LPA = ADDR_W'(LPA_ADDR);
  localparam logic [ADDR_W-1:0] A_QP  = ADDR_W'(QP_ADDR);

  always_comb begin
    hit_bsr_o = (addr_i == A_BSR);
    hit_lpa_o = (addr_i == A_LPA);
    hit_qp_o  = (addr_i == A_QP);
    clr_o     = stb_i && (hit_bsr_o || hit_qp_o);
  end
endmodule

// File: rtl/rd_mux.sv
module rd_mux
  import phy_stat_pkg::*;
#(
  parameter bit ANEG_ABLE = 1'b1
) (
  input  logic             hit_bsr_i,
  input  logic             hit_lpa_i,
  input  logic             hit_qp_i,
  input  stat_bits_t       bits_i,
  output logic [REG_W-1:0] data_o
);
  always_comb begin
    data_o = '0;
    if (hit_bsr_i)      data_o = bsr_word(bits_i.rf_latched, ANEG_ABLE, bits_i.link_latched);
    else if (hit_lpa_i) data_o = lpa_word(bits_i.rf_copy);
    else if (hit_qp_i)  data_o = qp_word(bits_i.rf_latched, bits_i.link_latched);
  end
endmodule

// File: rtl/phy_latch_status.sv
module phy_latch_status
  import phy_stat_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int BSR_ADDR  = 1,
  parameter int LPA_ADDR  = 5,
  parameter int QP_ADDR   = 17,
  parameter bit ANEG_ABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_stb,
  input  logic              lcw_stb,
  input  logic              lcw_rfault,
  input  logic              link_ok,
  output logic [15:0]       rd_data
);
  // named internal events
  logic       hit_bsr, hit_lpa, hit_qp;
  logic       rd_clr_evt;
  logic       rf_set_evt;
  stat_bits_t bits;

  assign rf_set_evt = lcw_stb && lcw_rfault;

  reg_decode #(
    .ADDR_W(ADDR_W), .BSR_ADDR(BSR_ADDR), .LPA_ADDR(LPA_ADDR), .QP_ADDR(QP_ADDR)
  ) u_dec (
    .addr_i(rd_addr), .stb_i(rd_stb),
    .hit_bsr_o(hit_bsr), .hit_lpa_o(hit_lpa), .hit_qp_o(hit_qp), .clr_o(rd_clr_evt)
  );

  lh_bit u_rf_lh (
    .clk(clk), .rst(rst), .set_i(rf_set_evt), .clr_i(rd_clr_evt), .q_o(bits.rf_latched)
  );

  ll_bit u_link_ll (
    .clk(clk), .rst(rst), .lvl_i(link_ok), .clr_i(rd_clr_evt), .q_o(bits.link_latched)
  );

  // non-latching copy of the last received remote-fault flag
  always_ff @(posedge clk) begin
    if (rst)          bits.rf_copy <= 1'b0;
    else if (lcw_stb) bits.rf_copy <= lcw_rfault;
  end

  rd_mux #(.ANEG_ABLE(ANEG_ABLE)) u_mux (
    .hit_bsr_i(hit_bsr), .hit_lpa_i(hit_lpa), .hit_qp_i(hit_qp),
    .bits_i(bits), .data_o(rd_data)
  );

  AST_COPY_TRACK: assert property (@(posedge clk) disable iff (rst)
    lcw_stb |=> (rd_data[LPA_RF_POS] == $past(lcw_rfault)) || !hit_lpa);          // R3
  AST_LPA_NOCLR:  assert property (@(posedge clk) disable iff (rst)
    (rd_stb && hit_lpa && bits.rf_latched) |=> bits.rf_latched);                 // R3
  AST_ANEG_BIT:   assert property (@(posedge clk) disable iff (rst)
    hit_bsr |-> (rd_data[BSR_ANEG_POS] == ANEG_ABLE));                           // R4
  AST_RACE_RF:    assert property (@(posedge clk) disable iff (rst)
    (rf_set_evt && rd_clr_evt) |=> bits.rf_latched);                             // R7
  AST_UNMAPPED:   assert property (@(posedge clk) disable iff (rst)
    !(hit_bsr || hit_lpa || hit_qp) |-> (rd_data == 16'h0000));                  // R9
  AST_ALIAS_SAME: assert property (@(posedge clk) disable iff (rst)
    hit_qp |-> (rd_data[QP_RF_POS] == bits.rf_latched));                         // R2
  AST_RST_STATE:  assert property (@(posedge clk)
    rst |=> (!bits.rf_latched && !bits.link_latched && !bits.rf_copy));          // R8
endmodule

// File: tb/phy_latch_status_tb.sv
module phy_latch_status_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_addr = '0;
  logic        rd_stb = 1'b0;
  logic        lcw_stb = 1'b0;
  logic        lcw_rfault = 1'b0;
  logic        link_ok = 1'b1;
  logic [15:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  phy_latch_status u_dut (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_stb(rd_stb),
    .lcw_stb(lcw_stb), .lcw_rfault(lcw_rfault), .link_ok(link_ok), .rd_data(rd_data)
  );

  // expected word builders restated from the requirements
  function automatic logic [15:0] exp_bsr(input bit rf, input bit lnk);
    return (16'(rf) << 4) | 16'h0008 | (16'(lnk) << 2);
  endfunction
  function automatic logic [15:0] exp_qp(input bit rf, input bit lnk);
    return (16'(rf) << 1) | 16'(lnk);
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  // one strobed read; data sampled before the edge that acts on it
  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    rd_addr = a; rd_stb = 1'b1;
    #2 chk(req, rd_data, exp);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic lcw(input bit rf);
    @(negedge clk);
    lcw_stb = 1'b1; lcw_rfault = rf;
    @(negedge clk);
    lcw_stb = 1'b0; lcw_rfault = 1'b0;
  endtask

  task automatic t_reset;
    rd(5'd17, 16'h0000, "R8 qp after reset");
    rd(5'd5,  16'h0000, "R8 lpa after reset");
    rd(5'd1,  exp_bsr(0, 1), "R6 link reloaded, R4 aneg");
  endtask

  task automatic t_rf_latch;
    lcw(1'b1);
    lcw(1'b0);
    rd(5'd5,  16'h0000, "R3 copy follows last word");
    rd(5'd1,  exp_bsr(1, 1), "R1 latched across zero word");
    rd(5'd1,  exp_bsr(0, 1), "R2 cleared by address 1 read");
    rd(5'd17, exp_qp(0, 1),  "R2 alias also cleared");
  endtask

  task automatic t_alias;
    lcw(1'b1);
    rd(5'd5,  16'h2000,     "R3 copy set");
    rd(5'd5,  16'h2000,     "R3 lpa read keeps copy");
    rd(5'd17, exp_qp(1, 1), "R3 lpa read did not clear, R2 alias");
    rd(5'd1,  exp_bsr(0, 1), "R2 address 17 read cleared");
  endtask

  task automatic t_race_rf;
    @(negedge clk);
    rd_addr = 5'd1; rd_stb = 1'b1; lcw_stb = 1'b1; lcw_rfault = 1'b1;
    #2 chk("R2 pre-clear data in race", rd_data, exp_bsr(0, 1));
    @(negedge clk);
    rd_stb = 1'b0; lcw_stb = 1'b0; lcw_rfault = 1'b0;
    rd(5'd17, exp_qp(1, 1), "R7 set wins over clear");
    rd(5'd1,  exp_bsr(0, 1), "R2 cleared afterwards");
  endtask

  task automatic t_link;
    @(negedge clk); link_ok = 1'b0;
    @(negedge clk); link_ok = 1'b1;
    rd(5'd17, exp_qp(0, 0), "R5 momentary drop captured");
    rd(5'd17, exp_qp(0, 1), "R6 reload to valid");
    @(negedge clk); link_ok = 1'b0;
    rd(5'd1, exp_bsr(0, 0), "R5 link down");
    rd(5'd1, exp_bsr(0, 0), "R6 reload while down stays 0");
    @(negedge clk); link_ok = 1'b1;
    rd(5'd1, exp_bsr(0, 0), "R5 stays 0 after recovery");
    rd(5'd1, exp_bsr(0, 1), "R6 reload after recovery");
  endtask

  task automatic t_race_link;
    @(negedge clk);
    rd_addr = 5'd17; rd_stb = 1'b1; link_ok = 1'b0;
    #2 chk("R2 pre-clear link data", rd_data, exp_qp(0, 1));
    @(negedge clk);
    rd_stb = 1'b0; link_ok = 1'b1;
    rd(5'd17, exp_qp(0, 0), "R7 drop wins over reload");
    rd(5'd17, exp_qp(0, 1), "R6 reload");
  endtask

  task automatic t_unmapped;
    lcw(1'b1);
    rd(5'd0,  16'h0000, "R9 address 0");
    rd(5'd2,  16'h0000, "R9 address 2");
    rd(5'd16, 16'h0000, "R9 address 16");
    rd(5'd31, 16'h0000, "R9 address 31");
    rd(5'd17, exp_qp(1, 1), "R9 unmapped reads cleared nothing");
    lcw(1'b0);
    rd(5'd5, 16'h0000, "R9 lpa other bits zero");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rf_latch();
    t_alias();
    t_race_rf();
    t_link();
    t_race_link();
    t_unmapped();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule